// File: doc/BRIEF.md
# Host Parallel Register Front End

This block sits between a host processor's asynchronous 16-bit parallel bus and the register and FIFO logic of a serial-bus message processor. The host pins are a select line (active low), a read/not-write line, a strobe (active low) and a four-bit register address. The block passes these pins through a synchronizer into the block clock domain. A write is committed when the strobe returns high. The bus is driven while a read strobe is held low. The bidirectional data bus is modelled as a data-out vector plus an output-enable, and the pad itself lives outside the block.

The register address used for decoding is the bitwise OR of the address pins and four software bits held in the control register. The operating mode is formed the same way, from two mode pins OR-ed with two control bits. The block keeps the control register and the two command-word registers. It emits a one-cycle push strobe with data for the transmit FIFO and a one-cycle pop strobe for the receive FIFO, and it mirrors the FIFO's empty flag back to the host. Master reset comes either from a pin or from control bit 0. It clears everything except the control register and is also exported to the FIFOs.

Outputs are registered. A pin change becomes visible on the outputs within SYNC_STAGES+2 clock cycles.

Top module: `hif_frontend`

## Requirements
- R1: `host_doe` is 1 only while select is low, read/not-write is 1 and the strobe is low. It is 0 when select is high, when read/not-write is 0, or when the strobe is high.
- R2: A write is committed only on a low-to-high strobe transition while select is low and read/not-write is 0. A strobe cycle with read/not-write at 1 or with select high changes no register.
- R3: The decode address is the bitwise OR of `host_addr` and control bits 10:7, where bit 7 ORs with address bit 0 and bit 10 ORs with address bit 3.
- R4: `mode_o` is {`pin_rt` OR control bit 3, `pin_bc` OR control bit 2}. The encodings are 2'b01 bus controller, 2'b10 remote terminal, 2'b11 monitor without an address and 2'b00 monitor with an address.
- R5: Write decode works as follows. Address bit 2 set writes the control register. Low bits 000 write command word 1 and low bits 001 write command word 2. Low bits 010 push the bus value into the transmit FIFO. Low bits 011 have no effect. Address bit 3 is ignored for writes.
- R6: Read decode works as follows. Address 1100 returns the control register and does not pop. Address 0100 returns the receive FIFO head and pops exactly once, at the strobe's rising edge. Every other address reads 0.
- R7: Master reset is active while `pin_mr` or control bit 0 is 1. During master reset `mreset_o` is 1, both command words read 0, command writes and transmit pushes are ignored, and the control register keeps its value and stays writable.
- R8: A control write whose resulting mode is bus controller stores bit 6 as 0. In any other mode bit 6 is stored as written.
- R9: `fifo_empty_o` is 0 while the receive FIFO holds data and goes to 1 after the host pops the last word.
- R10: Synchronous `rst` clears the control register, the command words and all strobes, and leaves the data bus undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n | input | 1 | Host select, active low |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_stb | input | 1 | Host strobe, active low; write commits on its rising edge |
| host_addr | input | AW | Register address pins |
| host_din | input | DW | Data from host |
| host_dout | output | DW | Read data toward the pad |
| host_doe | output | 1 | Pad output enable |
| pin_bc | input | 1 | Mode pin, OR-ed with control bit 2 |
| pin_rt | input | 1 | Mode pin, OR-ed with control bit 3 |
| pin_mr | input | 1 | Master reset pin, active high |
| rxf_data | input | DW | Receive FIFO head word |
| rxf_empty | input | 1 | Receive FIFO empty flag |
| ctrl_o | output | DW | Control register |
| mode_o | output | 2 | Effective operating mode |
| mreset_o | output | 1 | Master reset toward FIFOs and protocol logic |
| cmd1_o | output | DW | Command word 1 |
| cmd2_o | output | DW | Command word 2 |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| tx_data_o | output | DW | Transmit FIFO push data |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| fifo_empty_o | output | 1 | Mirrored receive FIFO empty flag |

## Verification
The hardest situation to reach is the self-referencing address merge. Once control bits 10:7 are non-zero, the pins alone no longer choose the register. A write intended for another register can then land in the control register and rewrite the very bits that steered it. The stimulus sets only the software bit that ORs with address bit 2. It then reads the control register through pin address 1000 and clears the bits through pin address 0000. The other hard case is a long-held read strobe on the FIFO address: the strobe is kept low and then high for many cycles to show that only one pop is issued.

// File: rtl/hif_pkg.sv
package hif_pkg;
  typedef enum logic [1:0] {
    MODE_MON_ADDR = 2'b00,
    MODE_BC       = 2'b01,
    MODE_RT       = 2'b10,
    MODE_MON      = 2'b11
  } hif_mode_t;

  localparam int CTRL_MR_BIT  = 0;
  localparam int CTRL_BC_BIT  = 2;
  localparam int CTRL_RT_BIT  = 3;
  localparam int CTRL_RES_BIT = 6;
  localparam int CTRL_RA_LSB  = 7;

  localparam logic [3:0] RD_CTRL_ADDR = 4'b1100;
  localparam logic [3:0] RD_RXF_ADDR  = 4'b0100;
  localparam logic [2:0] WR_CMD1_LOW  = 3'b000;
  localparam logic [2:0] WR_CMD2_LOW  = 3'b001;
  localparam logic [2:0] WR_TXF_LOW   = 3'b010;
endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hif_decode.sv
module hif_decode
  import hif_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0] pin_addr,
  input  logic [AW-1:0] sw_addr,
  output logic [AW-1:0] eff_addr,
  output logic          wr_ctrl,
  output logic          wr_cmd1,
  output logic          wr_cmd2,
  output logic          wr_txf,
  output logic          rd_ctrl,
  output logic          rd_rxf
);
  always_comb begin
    eff_addr = pin_addr | sw_addr;
    wr_ctrl  = eff_addr[2];
    wr_cmd1  = !eff_addr[2] && (eff_addr[1:0] == WR_CMD1_LOW[1:0]);
    wr_cmd2  = !eff_addr[2] && (eff_addr[1:0] == WR_CMD2_LOW[1:0]);
    wr_txf   = !eff_addr[2] && (eff_addr[1:0] == WR_TXF_LOW[1:0]);
    rd_ctrl  = (eff_addr == RD_CTRL_ADDR);
    rd_rxf   = (eff_addr == RD_RXF_ADDR);
  end
endmodule

// File: rtl/hif_frontend.sv
module hif_frontend
  import hif_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-1:0] CTRL_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sel_n,
  input  logic          host_rnw,
  input  logic          host_stb,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_doe,
  input  logic          pin_bc,
  input  logic          pin_rt,
  input  logic          pin_mr,
  input  logic [DW-1:0] rxf_data,
  input  logic          rxf_empty,
  output logic [DW-1:0] ctrl_o,
  output logic [1:0]    mode_o,
  output logic          mreset_o,
  output logic [DW-1:0] cmd1_o,
  output logic [DW-1:0] cmd2_o,
  output logic          tx_push_o,
  output logic [DW-1:0] tx_data_o,
  output logic          rx_pop_o,
  output logic          fifo_empty_o
);
  localparam int SW = 6 + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {3'b000, 3'b101, {AW{1'b0}}, {DW{1'b0}}};

  logic [SW-1:0] s_vec;
  logic          s_mr, s_rt, s_bc, s_sel_n, s_rnw, s_stb;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_din;

  hif_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst(rst),
    .d({pin_mr, pin_rt, pin_bc, host_sel_n, host_rnw, host_stb, host_addr, host_din}),
    .q(s_vec)
  );
  assign {s_mr, s_rt, s_bc, s_sel_n, s_rnw, s_stb, s_addr, s_din} = s_vec;

  logic [DW-1:0] ctrl_q;
  logic          stb_d;
  logic          stb_rise, wr_ev, rd_ev, mres;
  logic [AW-1:0] eff_addr;
  logic          wr_ctrl, wr_cmd1, wr_cmd2, wr_txf, rd_ctrl, rd_rxf;
  logic [DW-1:0] ctrl_new;
  logic [1:0]    new_mode;

  hif_decode #(.AW(AW)) dec_i (
    .pin_addr(s_addr),
    .sw_addr(ctrl_q[CTRL_RA_LSB +: AW]),
    .eff_addr(eff_addr),
    .wr_ctrl(wr_ctrl), .wr_cmd1(wr_cmd1), .wr_cmd2(wr_cmd2), .wr_txf(wr_txf),
    .rd_ctrl(rd_ctrl), .rd_rxf(rd_rxf)
  );

  always_comb begin
    stb_rise = s_stb && !stb_d;
    wr_ev    = stb_rise && !s_sel_n && !s_rnw;
    rd_ev    = stb_rise && !s_sel_n && s_rnw;
    mres     = s_mr || ctrl_q[CTRL_MR_BIT];
    new_mode = {s_rt | s_din[CTRL_RT_BIT], s_bc | s_din[CTRL_BC_BIT]};
    ctrl_new = s_din;
    if (new_mode == MODE_BC) ctrl_new[CTRL_RES_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_d  <= 1'b1;
      ctrl_q <= CTRL_RST;
    end else begin
      stb_d <= s_stb;
      if (wr_ev && wr_ctrl) ctrl_q <= ctrl_new;
    end
  end
  assign ctrl_o = ctrl_q;

  always_ff @(posedge clk) begin
    if (rst || mres) begin
      cmd1_o <= '0;
      cmd2_o <= '0;
    end else begin
      if (wr_ev && wr_cmd1) cmd1_o <= s_din;
      if (wr_ev && wr_cmd2) cmd2_o <= s_din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_push_o    <= 1'b0;
      tx_data_o    <= '0;
      rx_pop_o     <= 1'b0;
      host_doe     <= 1'b0;
      host_dout    <= '0;
      mode_o       <= MODE_MON_ADDR;
      mreset_o     <= 1'b0;
      fifo_empty_o <= 1'b1;
    end else begin
      tx_push_o <= wr_ev && wr_txf && !mres;
      if (wr_ev && wr_txf && !mres) tx_data_o <= s_din;
      rx_pop_o  <= rd_ev && rd_rxf && !mres;
      host_doe  <= !s_sel_n && s_rnw && !s_stb;
      if (!s_sel_n && s_rnw)
        host_dout <= rd_ctrl ? ctrl_q : (rd_rxf ? rxf_data : '0);
      else
        host_dout <= '0;
      mode_o       <= {s_rt | ctrl_q[CTRL_RT_BIT], s_bc | ctrl_q[CTRL_BC_BIT]};
      mreset_o     <= mres;
      fifo_empty_o <= rxf_empty;
    end
  end
endmodule

// File: rtl/hif_frontend_chk.sv
module hif_frontend_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          s_sel_n,
  input logic          host_doe,
  input logic          tx_push_o,
  input logic          rx_pop_o,
  input logic          mreset_o,
  input logic [DW-1:0] cmd1_o,
  input logic [DW-1:0] cmd2_o
);
  a_r1_no_drive_unselected: assert property (@(posedge clk) disable iff (rst)
    s_sel_n |=> !host_doe);

  a_r2_push_single: assert property (@(posedge clk) disable iff (rst)
    tx_push_o |=> !tx_push_o);

  a_r6_pop_single: assert property (@(posedge clk) disable iff (rst)
    rx_pop_o |=> !rx_pop_o);

  a_r7_cmd_cleared: assert property (@(posedge clk) disable iff (rst)
    mreset_o |-> (cmd1_o == '0 && cmd2_o == '0));

  a_r7_no_push_in_reset: assert property (@(posedge clk) disable iff (rst)
    mreset_o |-> !tx_push_o);

  a_r7_no_pop_in_reset: assert property (@(posedge clk) disable iff (rst)
    mreset_o |-> !rx_pop_o);
endmodule

bind hif_frontend hif_frontend_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .s_sel_n(s_sel_n), .host_doe(host_doe),
  .tx_push_o(tx_push_o), .rx_pop_o(rx_pop_o), .mreset_o(mreset_o),
  .cmd1_o(cmd1_o), .cmd2_o(cmd2_o)
);

// File: tb/hif_frontend_tb_top.sv
module hif_frontend_tb_top;
  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic        sel_n = 1, rnw = 1, stb = 1, pbc = 0, prt = 1, pmr = 0;
  logic [3:0]  addr = 0;
  logic [15:0] din = 0;
  logic [15:0] dout, ctrl, cmd1, cmd2, txd, rxd;
  logic        doe, mres, push, pop, empty, rxe;
  logic [1:0]  mode;

  hif_frontend dut_i (
    .clk(clk), .rst(rst), .host_sel_n(sel_n), .host_rnw(rnw), .host_stb(stb),
    .host_addr(addr), .host_din(din), .host_dout(dout), .host_doe(doe),
    .pin_bc(pbc), .pin_rt(prt), .pin_mr(pmr), .rxf_data(rxd), .rxf_empty(rxe),
    .ctrl_o(ctrl), .mode_o(mode), .mreset_o(mres), .cmd1_o(cmd1), .cmd2_o(cmd2),
    .tx_push_o(push), .tx_data_o(txd), .rx_pop_o(pop), .fifo_empty_o(empty)
  );

  // receive FIFO model
  logic [15:0] rxmem [4];
  int rd_ptr = 0, rx_cnt = 0, pops = 0, pushes = 0;
  assign rxd = rxmem[rd_ptr];
  assign rxe = (rx_cnt == 0);
  always @(negedge clk) begin
    if (pop) begin pops++; if (rx_cnt > 0) begin rd_ptr++; rx_cnt--; end end
    if (push) pushes++;
  end

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    sel_n = 0; rnw = 0; addr = a; din = d; stb = 1; settle();
    stb = 0; settle(); stb = 1; settle(); sel_n = 1; settle();
  endtask

  task automatic rd_begin(logic [3:0] a);
    sel_n = 0; rnw = 1; addr = a; stb = 0; settle();
  endtask

  task automatic rd_end();
    stb = 1; settle(); sel_n = 1; settle();
  endtask

  // {addr, data, field(0 cmd1,1 cmd2,2 ctrl,3 txdata), expected}
  localparam logic [37:0] VEC [9] = '{
    {4'b0000, 16'h1234, 2'd0, 16'h1234},
    {4'b1000, 16'h5678, 2'd0, 16'h5678},
    {4'b0001, 16'hABCD, 2'd1, 16'hABCD},
    {4'b1001, 16'h0F0F, 2'd1, 16'h0F0F},
    {4'b0100, 16'h0040, 2'd2, 16'h0040},
    {4'b1111, 16'h0030, 2'd2, 16'h0030},
    {4'b0010, 16'h9999, 2'd3, 16'h9999},
    {4'b0011, 16'h7777, 2'd0, 16'h5678},
    {4'b0110, 16'h0000, 2'd2, 16'h0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    repeat (4) @(negedge clk);
    rst = 0; settle();
    // R10 reset state
    chk("R10 ctrl", ctrl, 16'h0);
    chk("R10 cmd1", cmd1, 16'h0);
    chk("R10 doe", {15'b0, doe}, 16'h0);
    chk("R10 mreset", {15'b0, mres}, 16'h0);
    chk("R9 empty at start", {15'b0, empty}, 16'h1);

    // R5 table of writes
    for (int i = 0; i < 9; i++) begin
      int p0;
      p0 = pushes;
      wr(VEC[i][37:34], VEC[i][33:18]);
      case (VEC[i][17:16])
        2'd0: got = cmd1;
        2'd1: got = cmd2;
        2'd2: got = ctrl;
        default: got = txd;
      endcase
      chk($sformatf("R5 vector %0d", i), got, VEC[i][15:0]);
      chk($sformatf("R5 push count %0d", i), 16'(pushes - p0),
          (VEC[i][17:16] == 2'd3) ? 16'd1 : 16'd0);
    end

    // R1 bus drive
    sel_n = 0; rnw = 1; stb = 0; addr = 4'b0011; settle();
    chk("R1 drive on read", {15'b0, doe}, 16'h1);
    chk("R6 other addr reads 0", dout, 16'h0);
    stb = 1; settle();
    chk("R1 off strobe high", {15'b0, doe}, 16'h0);
    rnw = 0; stb = 0; addr = 4'b0011; settle();
    chk("R1 off on write", {15'b0, doe}, 16'h0);
    stb = 1; settle();
    sel_n = 1; rnw = 1; stb = 0; settle();
    chk("R1 off unselected", {15'b0, doe}, 16'h0);
    stb = 1; settle();

    // R2 ignored strobes
    sel_n = 0; rnw = 1; addr = 4'b0000; din = 16'hDEAD; stb = 0; settle(); stb = 1; settle();
    sel_n = 1; settle();
    chk("R2 read strobe no write", cmd1, 16'h5678);
    rnw = 0; din = 16'hBEEF; stb = 0; settle(); stb = 1; settle();
    chk("R2 unselected no write", cmd1, 16'h5678);

    // R3 address merge via ctrl[9]
    wr(4'b0100, 16'h0200);
    chk("R3 ctrl bit set", ctrl, 16'h0200);
    rd_begin(4'b1000);
    chk("R3 merged read of ctrl", dout, 16'h0200);
    rd_end();
    wr(4'b0000, 16'h0000);
    chk("R3 merged write to ctrl", ctrl, 16'h0000);
    chk("R3 cmd1 untouched", cmd1, 16'h5678);

    // R4 modes
    prt = 0; settle();
    chk("R4 monitor with addr", {14'b0, mode}, 16'h0);
    wr(4'b0100, 16'h0004);
    chk("R4 bc by software", {14'b0, mode}, 16'h1);
    prt = 1; settle();
    chk("R4 monitor no addr", {14'b0, mode}, 16'h3);
    wr(4'b0100, 16'h0000);
    chk("R4 rt by pin", {14'b0, mode}, 16'h2);

    // R8 bit 6
    prt = 0; settle();
    wr(4'b0100, 16'h0044);
    chk("R8 bit6 cleared in bc", ctrl, 16'h0004);
    wr(4'b0100, 16'h0048);
    chk("R8 bit6 kept in rt", ctrl, 16'h0048);
    wr(4'b0100, 16'h0000);
    prt = 1; settle();

    // R6 / R9 receive FIFO
    rxmem[0] = 16'hA001; rxmem[1] = 16'hA002; rxmem[2] = 16'hA003;
    rd_ptr = 0; rx_cnt = 3; settle();
    chk("R9 not empty", {15'b0, empty}, 16'h0);
    pops = 0;
    rd_begin(4'b0100);
    chk("R6 head word 1", dout, 16'hA001);
    chk("R6 no pop before rise", 16'(pops), 16'd0);
    stb = 1; repeat (20) @(negedge clk);
    chk("R6 single pop", 16'(pops), 16'd1);
    sel_n = 1; settle();
    rd_begin(4'b0100);
    chk("R6 head word 2", dout, 16'hA002);
    rd_end();
    rd_begin(4'b0100);
    chk("R6 head word 3", dout, 16'hA003);
    rd_end();
    chk("R6 three pops", 16'(pops), 16'd3);
    chk("R9 empty after last", {15'b0, empty}, 16'h1);
    wr(4'b0100, 16'h0030);
    rd_begin(4'b1100);
    chk("R6 ctrl read", dout, 16'h0030);
    rd_end();
    chk("R6 ctrl read no pop", 16'(pops), 16'd3);

    // R7 master reset by software bit
    wr(4'b0000, 16'h1111);
    wr(4'b0100, 16'h0031);
    chk("R7 mreset from bit", {15'b0, mres}, 16'h1);
    chk("R7 cmd1 cleared", cmd1, 16'h0);
    chk("R7 cmd2 cleared", cmd2, 16'h0);
    chk("R7 ctrl kept", ctrl, 16'h0031);
    begin
      int p0;
      p0 = pushes;
      wr(4'b0000, 16'h2222);
      wr(4'b0010, 16'h3333);
      chk("R7 cmd write blocked", cmd1, 16'h0);
      chk("R7 push blocked", 16'(pushes - p0), 16'd0);
    end
    wr(4'b0100, 16'h0030);
    chk("R7 release", {15'b0, mres}, 16'h0);
    wr(4'b0001, 16'h4444);
    pmr = 1; settle();
    chk("R7 mreset from pin", {15'b0, mres}, 16'h1);
    chk("R7 pin clears cmd2", cmd2, 16'h0);
    chk("R7 pin keeps ctrl", ctrl, 16'h0030);
    pmr = 0; settle();

    // R10 sync reset clears ctrl
    @(negedge clk); rst = 1; repeat (3) @(negedge clk); rst = 0; settle();
    chk("R10 ctrl cleared", ctrl, 16'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule